// File: doc/BRIEF.md
# Chip-Level Test Access Port with Core Run Control

This block is the chip-level test access port that a debug probe reaches through the board's five-wire JTAG header. A 16-state TAP controller, clocked by TCK and steered by TMS, moves scan data between TDI and TDO through a 4-bit instruction register and one of five data registers. These are a fixed identification code, a one-bit bypass stage, a request register, a sticky status register and a network-status register.

The request register gives a debug tool that has only the JTAG wires a way to raise the processor core's probe-mode request and its reset-break control. The status register keeps a record of two events: a request that was raised, and a probe-ready pulse from the core that may last only one TCK cycle. Without this record, a scan could easily miss such a pulse. The network-status register reports whether the core's own TAP is linked into the chain, the three power-good levels, and whether JTAG access is currently valid. All logic runs on TCK. The core-side inputs are assumed to be already synchronous to TCK. The TRST pin acts as a synchronous active-low reset.

Top module: `jrc_tap_top`

## Requirements
- R1: When trst_n is low at a rising TCK edge, the controller enters Test-Logic-Reset. It also enters Test-Logic-Reset after five rising edges with TMS high, from any state. In Test-Logic-Reset, the instruction register holds the identification opcode 4'h1, and probe_req and reset_break are 0.
- R2: The instruction register captures 4'b0001 in Capture-IR and shifts least-significant bit first. A new instruction takes effect only when the controller leaves Update-IR.
- R3: Opcode 4'h1 selects a 32-bit register that captures 32'h0E681013.
- R4: Opcode 4'hF, and any opcode not listed in R3, R5, R6 or R8, selects a 1-bit bypass stage that captures 0 and delays TDI by one shift.
- R5: Opcode 4'h4 selects a 2-bit request register. Bit 0 drives probe_req and bit 1 drives reset_break. Capture returns the current value. The outputs change only when the controller leaves Update-DR, never during Shift-DR.
- R6: Opcode 4'h5 selects a 2-bit status register. Bit 0 becomes 1 at any rising edge where probe_req is 1. Bit 1 becomes 1 at any rising edge where core_probe_rdy is 1, even for a single-cycle pulse. Both bits hold until they are cleared.
- R7: A status bit clears when a 1 is written to it at Update-DR. Writing 0 leaves the bit as it is. A set event in the same cycle wins over the clear. Test-Logic-Reset clears both bits.
- R8: Opcode 4'h6 selects a 5-bit network-status register that captures the following inputs: bit 0 core_tap_linked, bit 1 pwr_s0_ok, bit 2 pwr_s3_ok, bit 3 pwr_s5_ok, bit 4 dbg_valid.
- R9: TDO and tdo_en change only on the falling edge of TCK. tdo_en is 1 exactly while the controller is in Shift-DR or Shift-IR. When tdo_en is 0, TDO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising TCK |
| tms | input | 1 | Mode select steering the TAP state machine |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, updated on falling TCK |
| tdo_en | output | 1 | High while tdo carries shift data |
| core_probe_rdy | input | 1 | Probe-ready pulse from the core |
| core_tap_linked | input | 1 | Core TAP is linked into the scan chain |
| pwr_s0_ok | input | 1 | S0 power-good |
| pwr_s3_ok | input | 1 | S3 power-good |
| pwr_s5_ok | input | 1 | S5 power-good |
| dbg_valid | input | 1 | JTAG access valid (must be 1 in S0 before using the core TAP) |
| probe_req | output | 1 | Probe-mode request to the core |
| reset_break | output | 1 | Reset-break control to the core |

## Verification
The hardest case to reach is a status bit that is being cleared and set in the same cycle. The clear happens only on the one edge where the controller leaves Update-DR. The set must arrive on exactly that edge, or must be held continuously. The bench covers both forms. It holds probe_req high while it writes 1 to status bit 0. It also raises core_probe_rdy for the single update edge of a scan that writes 1 to status bit 1. A lone one-cycle ready pulse that is sent during Run-Test/Idle, well before the status scan, shows that the sticky capture holds.

// File: rtl/jrc_pkg.sv
// Shared types and constants for the chip-level TAP with run control.
// Assumes a 4-bit instruction register and data registers no wider than DR_MAX.
package jrc_pkg;
    typedef enum logic [3:0] {
        ST_TLR, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W   = 4;
    localparam int DR_MAX = 32;
    localparam int REQ_W  = 2;
    localparam int STAT_W = 2;
    localparam int NET_W  = 5;

    localparam logic [IR_W-1:0]   OP_IDCODE  = 4'h1;
    localparam logic [IR_W-1:0]   OP_REQ     = 4'h4;
    localparam logic [IR_W-1:0]   OP_STAT    = 4'h5;
    localparam logic [IR_W-1:0]   OP_NET     = 4'h6;
    localparam logic [IR_W-1:0]   OP_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0]   IR_CAPTURE = 4'b0001;
    localparam logic [DR_MAX-1:0] ID_VALUE   = 32'h0E681013;
endpackage

// File: rtl/jrc_fsm.sv
// TAP state machine: 16 states, steered by tms on rising tck.
// Assumes trst_n is a synchronous active-low reset that forces Test-Logic-Reset.
module jrc_fsm
    import jrc_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e nxt;

    // Next-state decode of the standard TAP graph.
    always_comb begin
        case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_TLR;
        endcase
    end

    // State register with synchronous test reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    // R1
    trst_to_tlr_chk: assert property (@(posedge tck) !trst_n |=> state == ST_TLR);
    // R1
    tms_hold_tlr_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR && tms) |=> state == ST_TLR);
endmodule

// File: rtl/jrc_ir.sv
// Instruction register: captures a fixed pattern, shifts LSB first, and applies
// the new opcode on leaving Update-IR. Assumes tap state from jrc_fsm.
module jrc_ir
    import jrc_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir,
    output logic            ir_so
);
    logic [IR_W-1:0] sr;

    // Capture and shift path of the instruction register.
    always_ff @(posedge tck) begin
        if (!trst_n)                sr <= IR_CAPTURE;
        else if (state == ST_CAP_IR) sr <= IR_CAPTURE;
        else if (state == ST_SH_IR)  sr <= {tdi, sr[IR_W-1:1]};
    end

    // Active instruction, loaded only in Update-IR, reset to the ID opcode.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) ir <= OP_IDCODE;
        else if (state == ST_UPD_IR)    ir <= sr;
    end

    assign ir_so = sr[0];

    // R2
    ir_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(ir) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR));
endmodule

// File: rtl/jrc_dr.sv
// Data register bank: one shared shift path whose length and capture value
// follow the opcode, plus the request register and sticky status bits.
// Assumes core_probe_rdy and the status inputs are synchronous to tck.
module jrc_dr
    import jrc_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    input  logic [IR_W-1:0] ir,
    input  logic            core_probe_rdy,
    input  logic [NET_W-1:0] net_in,
    output logic            probe_req,
    output logic            reset_break,
    output logic            dr_so
);
    localparam int LW = $clog2(DR_MAX + 1);

    logic [DR_MAX-1:0] sr, cap_val, shifted, sh_next;
    logic [LW-1:0]     len;
    logic [STAT_W-1:0] seen;
    logic              upd_stat;

    // Selected register: capture value and shift length.
    always_comb begin
        case (ir)
            OP_IDCODE: begin cap_val = ID_VALUE;                       len = LW'(DR_MAX); end
            OP_REQ:    begin cap_val = DR_MAX'({reset_break, probe_req}); len = LW'(REQ_W); end
            OP_STAT:   begin cap_val = DR_MAX'(seen);                   len = LW'(STAT_W); end
            OP_NET:    begin cap_val = DR_MAX'(net_in);                 len = LW'(NET_W); end
            default:   begin cap_val = '0;                              len = LW'(1); end
        endcase
    end

    // Shift step: tdi enters at the top bit of the selected length.
    always_comb begin
        shifted = {1'b0, sr[DR_MAX-1:1]};
        for (int i = 0; i < DR_MAX; i++)
            sh_next[i] = (i == int'(len) - 1) ? tdi : shifted[i];
    end

    // Shared data shift register.
    always_ff @(posedge tck) begin
        if (!trst_n)                 sr <= '0;
        else if (state == ST_CAP_DR) sr <= cap_val;
        else if (state == ST_SH_DR)  sr <= sh_next;
    end

    // Request register, written only on leaving Update-DR.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) {reset_break, probe_req} <= '0;
        else if (state == ST_UPD_DR && ir == OP_REQ) {reset_break, probe_req} <= sr[REQ_W-1:0];
    end

    assign upd_stat = (state == ST_UPD_DR) && (ir == OP_STAT);

    // Sticky status bits: set wins over write-one clear; TAP reset clears.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) seen <= '0;
        else seen <= (upd_stat ? (seen & ~sr[STAT_W-1:0]) : seen) | {core_probe_rdy, probe_req};
    end

    assign dr_so = sr[0];

    // R5
    req_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable({reset_break, probe_req}) |-> ($past(state) == ST_UPD_DR || $past(state) == ST_TLR));
    // R6
    rdy_caught_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (core_probe_rdy && state != ST_TLR) |=> seen[1]);
    // R6
    req_caught_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (probe_req && state != ST_TLR) |=> seen[0]);
    // R7
    tlr_clears_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (seen == '0 && !probe_req && !reset_break));
endmodule

// File: rtl/jrc_tap_top.sv
// Chip-level TAP top: state machine, instruction register, data register bank
// and the falling-edge TDO stage. Assumes all inputs are synchronous to tck.
module jrc_tap_top
    import jrc_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    input  logic core_probe_rdy,
    input  logic core_tap_linked,
    input  logic pwr_s0_ok,
    input  logic pwr_s3_ok,
    input  logic pwr_s5_ok,
    input  logic dbg_valid,
    output logic probe_req,
    output logic reset_break
);
    tap_state_e      state;
    logic [IR_W-1:0] ir;
    logic            ir_so, dr_so;

    jrc_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

    jrc_ir u_ir (.tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .ir(ir), .ir_so(ir_so));

    jrc_dr u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .ir(ir),
        .core_probe_rdy(core_probe_rdy),
        .net_in({dbg_valid, pwr_s5_ok, pwr_s3_ok, pwr_s0_ok, core_tap_linked}),
        .probe_req(probe_req), .reset_break(reset_break), .dr_so(dr_so)
    );

    // Output stage on falling tck: drive data only in a shift state.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SH_DR) || (state == ST_SH_IR);
            tdo    <= (state == ST_SH_IR) ? ir_so : ((state == ST_SH_DR) ? dr_so : 1'b0);
        end
    end

    // R9
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n) !tdo_en |-> !tdo);
endmodule

// File: tb/tb_jrc_tap_top.sv
`timescale 1ns/100ps
module tb_jrc_tap_top;
    import jrc_pkg::*;

    logic tck = 0, trst_n = 0, tms = 1, tdi = 0, rdy_pin = 0;
    logic linked = 0, s0 = 0, s3 = 0, s5 = 0, vld = 0;
    logic tdo, tdo_en, probe_req, reset_break;

    jrc_tap_top dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .core_probe_rdy(rdy_pin), .core_tap_linked(linked), .pwr_s0_ok(s0),
        .pwr_s3_ok(s3), .pwr_s5_ok(s5), .dbg_valid(vld),
        .probe_req(probe_req), .reset_break(reset_break)
    );

    always #2 tck = ~tck;   // 250 MHz

    int checks = 0, errors = 0;
    bit done = 0;

    // Behavioural reference model state.
    tap_state_e m_state = ST_TLR;
    logic [3:0]  m_ir = 4'h1, m_irwr = 4'h0;
    logic        m_req = 0, m_rb = 0, m_on = 0;
    logic [1:0]  m_seen = 0;
    logic [31:0] m_cap = 0, m_wr = 0;
    int          m_len = 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic tap_state_e nx(input tap_state_e s, input logic t);
        case (s)
            ST_TLR:    return t ? ST_TLR : ST_IDLE;
            ST_IDLE:   return t ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return t ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR, ST_SH_DR: return t ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return t ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return t ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return t ? ST_UPD_DR : ST_SH_DR;
            ST_SEL_IR: return t ? ST_TLR : ST_CAP_IR;
            ST_CAP_IR, ST_SH_IR: return t ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return t ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return t ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return t ? ST_UPD_IR : ST_SH_IR;
            default:   return t ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic int len_of(input logic [3:0] op);
        case (op) 4'h1: return 32; 4'h4: return 2; 4'h5: return 2; 4'h6: return 5; default: return 1; endcase
    endfunction

    function automatic logic [31:0] cap_of(input logic [3:0] op);
        case (op)
            4'h1: return 32'h0E681013;
            4'h4: return {30'b0, m_rb, m_req};
            4'h5: return {30'b0, m_seen};
            4'h6: return {27'b0, vld, s5, s3, s0, linked};
            default: return 32'b0;
        endcase
    endfunction

    // One TCK cycle: drive at falling edge, read tdo before the rise, update model.
    task automatic step(input logic t, input logic d, output logic so);
        logic [1:0] nseen;
        @(negedge tck); #0.5;
        tms = t; tdi = d;
        so = tdo;
        @(posedge tck);
        if (!trst_n) begin
            m_state = ST_TLR; m_ir = 4'h1; m_req = 0; m_rb = 0; m_seen = 0;
        end else begin
            nseen = m_seen;
            if (m_state == ST_UPD_DR && m_ir == 4'h5) nseen = nseen & ~m_wr[1:0];
            nseen = nseen | {rdy_pin, m_req};
            if (m_state == ST_TLR) begin nseen = 0; m_ir = 4'h1; m_req = 0; m_rb = 0; end
            if (m_state == ST_CAP_DR) begin m_cap = cap_of(m_ir); m_len = len_of(m_ir); end
            if (m_state == ST_CAP_IR) begin m_cap = 32'h1; m_len = 4; end
            if (m_state == ST_UPD_DR && m_ir == 4'h4) begin m_req = m_wr[0]; m_rb = m_wr[1]; end
            if (m_state == ST_UPD_IR) m_ir = m_irwr;
            m_seen = nseen;
            m_state = nx(m_state, t);
        end
        #0.4;
        if (m_on) check("R9 tdo stable across rising edge", tdo, so);
    endtask

    task automatic idle(input int n);
        logic so;
        for (int i = 0; i < n; i++) step(0, 0, so);
    endtask

    // Scan n bits from Run-Test/Idle and back; checks shifted-out data vs model.
    task automatic scan(input string tag, input bit is_ir, input int n, input logic [63:0] din,
                        input bit pulse_upd, output logic [63:0] dout);
        logic so;
        logic [63:0] exp;
        dout = 0;
        step(1, 0, so);
        if (is_ir) step(1, 0, so);
        step(0, 0, so);
        step(0, 0, so);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], so);
            dout[i] = so;
        end
        for (int j = 0; j < 32; j++) m_wr[j] = (j < m_len && n - m_len + j >= 0) ? din[n - m_len + j] : 1'b0;
        m_irwr = m_wr[3:0];
        exp = 0;
        for (int i = 0; i < n; i++) exp[i] = (i < m_len) ? m_cap[i] : din[i - m_len];
        step(1, 0, so);
        if (pulse_upd) rdy_pin = 1;
        step(0, 0, so);
        rdy_pin = 0;
        check(tag, dout, exp);
    endtask

    // Per-cycle comparison of the core-side outputs and tdo_en against the model.
    always @(negedge tck) begin
        #1;
        if (m_on && !done) begin
            check("R5 probe_req vs model", probe_req, m_req);
            check("R5 reset_break vs model", reset_break, m_rb);
            check("R9 tdo_en vs model", tdo_en, (m_state == ST_SH_DR || m_state == ST_SH_IR));
            if (!tdo_en) check("R9 tdo low when idle", tdo, 0);
        end
    end

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] r;
        logic so;
        for (int i = 0; i < 3; i++) step(1, 0, so);
        trst_n = 1;
        m_on = 1;
        step(1, 0, so);
        check("R1 reset probe_req", probe_req, 0);
        check("R1 reset reset_break", reset_break, 0);
        check("R9 reset tdo_en", tdo_en, 0);
        step(0, 0, so);

        // R1/R3: default instruction reads the identification code.
        scan("R3 id code after reset", 0, 32, 64'h0, 0, r);
        check("R1 R3 id value", r[31:0], 32'h0E681013);

        // R2/R4: bypass by explicit opcode and by an unused opcode.
        scan("R2 ir capture pattern", 1, 4, 64'hF, 0, r);
        check("R2 ir capture 0001", r[3:0], 4'b0001);
        scan("R4 bypass delay", 0, 8, 64'hB5, 0, r);
        scan("R2 ir load unused", 1, 4, 64'h9, 0, r);
        scan("R4 unused opcode bypass", 0, 6, 64'h2D, 0, r);

        // R8: network status with two input patterns.
        scan("R2 ir load net", 1, 4, 64'h6, 0, r);
        {vld, s5, s3, s0, linked} = 5'b10110;
        scan("R8 net pattern a", 0, 5, 64'h0, 0, r);
        {vld, s5, s3, s0, linked} = 5'b01001;
        scan("R8 net pattern b", 0, 5, 64'h0, 0, r);

        // R5: assert probe request via JTAG alone.
        scan("R2 ir load req", 1, 4, 64'h4, 0, r);
        scan("R5 write req 01", 0, 2, 64'h1, 0, r);
        check("R5 probe_req set", probe_req, 1);
        scan("R5 read back req", 0, 2, 64'h1, 0, r);

        // R6/R7: request sticky; clearing while request held must not clear.
        scan("R2 ir load stat", 1, 4, 64'h5, 0, r);
        scan("R6 req seen", 0, 2, 64'h0, 0, r);
        check("R6 req bit set", r[0], 1);
        scan("R7 clear while held", 0, 2, 64'h1, 0, r);
        scan("R7 still set after clear", 0, 2, 64'h0, 0, r);
        check("R7 set wins on held req", r[0], 1);

        scan("R2 ir load req2", 1, 4, 64'h4, 0, r);
        scan("R5 write req 10", 0, 2, 64'h2, 0, r);
        check("R5 reset_break set", reset_break, 1);
        scan("R2 ir load stat2", 1, 4, 64'h5, 0, r);
        scan("R7 clear req bit", 0, 2, 64'h1, 0, r);
        scan("R7 req bit cleared", 0, 2, 64'h0, 0, r);
        check("R7 req bit now 0", r[0], 0);

        // R6: a one-cycle ready pulse is caught and held.
        rdy_pin = 1; step(0, 0, so); rdy_pin = 0;
        idle(3);
        scan("R6 rdy pulse caught", 0, 2, 64'h0, 0, r);
        check("R6 rdy bit set", r[1], 1);
        scan("R7 write zero keeps", 0, 2, 64'h0, 0, r);
        check("R7 rdy kept", r[1], 1);
        scan("R7 clear with pulse on update", 0, 2, 64'h2, 1, r);
        scan("R7 set wins at update", 0, 2, 64'h0, 0, r);
        check("R7 rdy still set", r[1], 1);
        scan("R7 clear rdy", 0, 2, 64'h2, 0, r);
        scan("R7 rdy cleared", 0, 2, 64'h0, 0, r);
        check("R7 rdy now 0", r[1], 0);

        // R1/R7: five TMS-high cycles reset the TAP and clear sticky state.
        rdy_pin = 1; step(0, 0, so); rdy_pin = 0;
        for (int i = 0; i < 5; i++) step(1, 0, so);
        check("R1 tms reset clears reset_break", reset_break, 0);
        step(0, 0, so);
        scan("R1 id after tms reset", 0, 32, 64'h0, 0, r);
        check("R1 id value again", r[31:0], 32'h0E681013);
        scan("R2 ir load stat3", 1, 4, 64'h5, 0, r);
        scan("R7 tap reset cleared", 0, 2, 64'h0, 0, r);
        check("R7 sticky zero after reset", r[1:0], 2'b00);

        idle(2);
        finish_run();
    end
endmodule